// File: doc/BRIEF.md
# Byte Arithmetic/Logic Unit with Status Flag Update

This block is the arithmetic and logic stage of a small 8-bit processor datapath. It takes two operands, an operation code, a bit index, a flag index and the present 8-bit status byte. It returns a result word and the status byte that should follow. The carry used by carry-consuming operations is the C bit of the incoming status byte. The T bit of that byte serves as the one-bit store for the bit-store and bit-load operations.

Each operation rewrites its own set of flags and copies every other flag through unchanged. The status byte is packed as, from bit 7 to bit 0: I, T, H, S, V, N, Z, C. H is the carry out of, or the borrow into, bit 3 (the top of the low half of the word). V is two's-complement overflow. S is always recomputed as N XOR V whenever N or V is written. Subtract-with-carry and compare-with-carry can only keep Z set or clear it, so a chain of byte-wise compares or subtractions yields a correct zero test over the whole multi-byte value.

By default both outputs are registered, so a result appears one clock after its inputs. A parameter turns the output stage into a purely combinational path. The data width is a parameter (even, at least 4). The status layout is fixed.

Top module: `byte_alu`

## Requirements
- R1: While reset is held, res_o and status_o read 0x00. With the output register enabled, the result and status for inputs present at a rising clock edge appear after that edge and are held until the next one. Status bits are I=7, T=6, H=5, S=4, V=3, N=2, Z=1, C=0.
- R2: ADD (op 0) gives A+B and ADC (op 1) gives A+B+C. Both write H (carry out of bit 3), C (carry out of bit 7), V (signed overflow), N (bit 7 of the result), Z (result is zero) and S=N^V.
- R3: SUB (op 2) gives A-B and SBC (op 3) gives A-B-C. CMP (op 4) and CMPC (op 5) compute the same flags as SUB and SBC but return A unchanged as the result. NEG (op 6) gives 0x00-A. All five write H and C as borrows, plus V, N, Z and S.
- R4: For SBC and CMPC, Z becomes 1 only if the difference is zero and Z was already 1. Otherwise Z becomes 0.
- R5: AND (op 7), OR (op 8) and XOR (op 9) write Z and N, clear V, and set S=N. C, H, T and I keep their incoming values.
- R6: INC (op 11) and DEC (op 12) write Z, N, V and S. V is set only for 0x7F+1 and for 0x80-1. C and H are preserved.
- R7: COM (op 10) gives 0xFF-A, sets C to 1, clears V, and writes N, Z and S.
- R8: LSL (op 13) shifts left, filling bit 0 with 0. LSR (op 14) shifts right, filling bit 7 with 0. ASR (op 15) shifts right and keeps bit 7. C takes the bit shifted out, N and Z follow the result, V=N^C and S=N^V.
- R9: ROL (op 16) puts the old C into bit 0 and old bit 7 into C. ROR (op 17) puts the old C into bit 7 and old bit 0 into C. Flags are set as in R8.
- R10: SWAP (op 18) exchanges the two halves of A. SER (op 19) returns all ones. Neither changes any status bit.
- R11: BST (op 20) copies A[bit_sel_i] into T and returns A. BLD (op 21) returns A with bit bit_sel_i replaced by T. Neither changes any other status bit.
- R12: FSET (op 22) sets status bit flag_sel_i and FCLR (op 23) clears it, returning A. Codes 24 to 31 return A and leave the status unchanged.
- R13: The I bit changes only through FSET or FCLR. The T bit changes only through FSET, FCLR or BST.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the output register |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_i | input | 5 | Operation code (see requirements) |
| a_i | input | DATA_W | First operand; the only operand for single-operand operations |
| b_i | input | DATA_W | Second operand |
| bit_sel_i | input | $clog2(DATA_W) | Bit index for BST and BLD |
| flag_sel_i | input | 3 | Status bit index for FSET and FCLR |
| status_i | input | 8 | Current status byte |
| res_o | output | DATA_W | Result word |
| status_o | output | 8 | Next status byte |

## Verification
The bound checker examines every cycle for the relationships that hold for any operand values. These are: flags are preserved by SWAP and by the logical operations; Z can never be newly set by the chained subtract and compare operations; I stays fixed outside the flag operations; S equals N XOR V after an add; compares return the first operand; and the addressed bit is set by FSET. The exact arithmetic values of H, C and V at the carry and overflow boundaries (0x7F+1, 0xFF+1, 0x80-1, negating 0x80) need known operands, so only the directed scenarios and the operand sweep against an independent flag model can demonstrate them. The same applies to shift and rotate carry movement and to the exact register timing.

// File: rtl/byte_alu_pkg.sv
`timescale 1ns/1ps
package byte_alu_pkg;

   typedef enum logic [4:0] {
      OP_ADD  = 5'd0,
      OP_ADC  = 5'd1,
      OP_SUB  = 5'd2,
      OP_SBC  = 5'd3,
      OP_CMP  = 5'd4,
      OP_CMPC = 5'd5,
      OP_NEG  = 5'd6,
      OP_AND  = 5'd7,
      OP_OR   = 5'd8,
      OP_XOR  = 5'd9,
      OP_COM  = 5'd10,
      OP_INC  = 5'd11,
      OP_DEC  = 5'd12,
      OP_LSL  = 5'd13,
      OP_LSR  = 5'd14,
      OP_ASR  = 5'd15,
      OP_ROL  = 5'd16,
      OP_ROR  = 5'd17,
      OP_SWAP = 5'd18,
      OP_SER  = 5'd19,
      OP_BST  = 5'd20,
      OP_BLD  = 5'd21,
      OP_FSET = 5'd22,
      OP_FCLR = 5'd23
   } alu_op_e;

   localparam int ST_W = 8;
   // Status bit positions; the order is fixed because downstream logic decodes it
   localparam int FL_C = 0;
   localparam int FL_Z = 1;
   localparam int FL_N = 2;
   localparam int FL_V = 3;
   localparam int FL_S = 4;
   localparam int FL_H = 5;
   localparam int FL_T = 6;
   localparam int FL_I = 7;

   // Which functional unit supplies the flag-source value
   typedef enum logic [1:0] {
      UNIT_PASS  = 2'd0,
      UNIT_ARITH = 2'd1,
      UNIT_LOGIC = 2'd2,
      UNIT_SHIFT = 2'd3
   } unit_sel_e;

endpackage

// File: rtl/byte_alu_arith.sv
`timescale 1ns/1ps
module byte_alu_arith
   import byte_alu_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  alu_op_e           op_i,
   input  logic [DATA_W-1:0] a_i,
   input  logic [DATA_W-1:0] b_i,
   input  logic              cin_i,
   output logic [DATA_W-1:0] res_o,
   output logic              c_o,
   output logic              h_o,
   output logic              v_o
);
   localparam int HB  = DATA_W / 2;
   localparam int MSB = DATA_W - 1;
   localparam logic [DATA_W-1:0] ONE = {{(DATA_W-1){1'b0}}, 1'b1};

   logic [DATA_W-1:0] x_op;
   logic [DATA_W-1:0] y_op;
   logic              ci;
   logic              is_sub;
   logic [DATA_W:0]   full;
   logic [HB:0]       low;

   // Steer every add-like and subtract-like operation onto one adder
   always_comb begin
      x_op   = a_i;
      y_op   = b_i;
      ci     = 1'b0;
      is_sub = 1'b0;
      case (op_i)
         OP_ADD:          ci = 1'b0;
         OP_ADC:          ci = cin_i;
         OP_SUB, OP_CMP:  is_sub = 1'b1;
         OP_SBC, OP_CMPC: begin
            is_sub = 1'b1;
            ci     = cin_i;
         end
         OP_NEG: begin
            x_op   = '0;
            y_op   = a_i;
            is_sub = 1'b1;
         end
         OP_INC: y_op = ONE;
         OP_DEC: begin
            y_op   = ONE;
            is_sub = 1'b1;
         end
         default: ci = 1'b0;
      endcase
   end

   always_comb begin
      if (is_sub) begin
         full = {1'b0, x_op} - {1'b0, y_op} - {{DATA_W{1'b0}}, ci};
         low  = {1'b0, x_op[HB-1:0]} - {1'b0, y_op[HB-1:0]} - {{HB{1'b0}}, ci};
      end else begin
         full = {1'b0, x_op} + {1'b0, y_op} + {{DATA_W{1'b0}}, ci};
         low  = {1'b0, x_op[HB-1:0]} + {1'b0, y_op[HB-1:0]} + {{HB{1'b0}}, ci};
      end
      res_o = full[MSB:0];
      c_o   = full[DATA_W];
      h_o   = low[HB];
      if (is_sub)
         v_o = (x_op[MSB] != y_op[MSB]) && (full[MSB] != x_op[MSB]);
      else
         v_o = (x_op[MSB] == y_op[MSB]) && (full[MSB] != x_op[MSB]);
   end

endmodule

// File: rtl/byte_alu_logic.sv
`timescale 1ns/1ps
module byte_alu_logic
   import byte_alu_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int SEL_W  = 3
) (
   input  alu_op_e           op_i,
   input  logic [DATA_W-1:0] a_i,
   input  logic [DATA_W-1:0] b_i,
   input  logic              t_i,
   input  logic [SEL_W-1:0]  bit_sel_i,
   output logic [DATA_W-1:0] res_o,
   output logic              bit_o
);
   localparam int HB  = DATA_W / 2;
   localparam int MSB = DATA_W - 1;

   always_comb begin
      res_o = a_i;
      case (op_i)
         OP_AND:  res_o = a_i & b_i;
         OP_OR:   res_o = a_i | b_i;
         OP_XOR:  res_o = a_i ^ b_i;
         OP_COM:  res_o = ~a_i;
         OP_SWAP: res_o = {a_i[HB-1:0], a_i[MSB:HB]};
         OP_SER:  res_o = '1;
         OP_BLD:  res_o[bit_sel_i] = t_i;
         default: res_o = a_i;
      endcase
   end

   assign bit_o = a_i[bit_sel_i];

endmodule

// File: rtl/byte_alu_shift.sv
`timescale 1ns/1ps
module byte_alu_shift
   import byte_alu_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  alu_op_e           op_i,
   input  logic [DATA_W-1:0] a_i,
   input  logic              cin_i,
   output logic [DATA_W-1:0] res_o,
   output logic              c_o
);
   localparam int MSB = DATA_W - 1;

   always_comb begin
      res_o = a_i;
      c_o   = cin_i;
      case (op_i)
         OP_LSL: begin
            res_o = {a_i[MSB-1:0], 1'b0};
            c_o   = a_i[MSB];
         end
         OP_LSR: begin
            res_o = {1'b0, a_i[MSB:1]};
            c_o   = a_i[0];
         end
         OP_ASR: begin
            res_o = {a_i[MSB], a_i[MSB:1]};
            c_o   = a_i[0];
         end
         OP_ROL: begin
            res_o = {a_i[MSB-1:0], cin_i};
            c_o   = a_i[MSB];
         end
         OP_ROR: begin
            res_o = {cin_i, a_i[MSB:1]};
            c_o   = a_i[0];
         end
         default: begin
            res_o = a_i;
            c_o   = cin_i;
         end
      endcase
   end

endmodule

// File: rtl/byte_alu.sv
`timescale 1ns/1ps
module byte_alu
   import byte_alu_pkg::*;
#(
   parameter int DATA_W  = 8,
   parameter bit OUT_REG = 1'b1,
   localparam int SEL_W  = $clog2(DATA_W)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [4:0]        op_i,
   input  logic [DATA_W-1:0] a_i,
   input  logic [DATA_W-1:0] b_i,
   input  logic [SEL_W-1:0]  bit_sel_i,
   input  logic [2:0]        flag_sel_i,
   input  logic [ST_W-1:0]   status_i,
   output logic [DATA_W-1:0] res_o,
   output logic [ST_W-1:0]   status_o
);
   localparam int MSB = DATA_W - 1;

   // Elaboration-time parameter checks
   if (DATA_W < 4 || (DATA_W % 2) != 0) begin : g_bad_width
      $error("byte_alu: DATA_W must be even and at least 4");
   end

   alu_op_e op;
   assign op = alu_op_e'(op_i);

   logic [DATA_W-1:0] ar_res, lg_res, sh_res;
   logic              ar_c, ar_h, ar_v, sh_c, lg_bit;

   byte_alu_arith #(.DATA_W(DATA_W)) i_arith (
      .op_i  (op),
      .a_i   (a_i),
      .b_i   (b_i),
      .cin_i (status_i[FL_C]),
      .res_o (ar_res),
      .c_o   (ar_c),
      .h_o   (ar_h),
      .v_o   (ar_v)
   );

   byte_alu_logic #(.DATA_W(DATA_W), .SEL_W(SEL_W)) i_logic (
      .op_i      (op),
      .a_i       (a_i),
      .b_i       (b_i),
      .t_i       (status_i[FL_T]),
      .bit_sel_i (bit_sel_i),
      .res_o     (lg_res),
      .bit_o     (lg_bit)
   );

   byte_alu_shift #(.DATA_W(DATA_W)) i_shift (
      .op_i  (op),
      .a_i   (a_i),
      .cin_i (status_i[FL_C]),
      .res_o (sh_res),
      .c_o   (sh_c)
   );

   // Unit selection and result steering
   unit_sel_e         unit;
   logic [DATA_W-1:0] flag_src;
   logic [DATA_W-1:0] res_d;

   always_comb begin
      case (op)
         OP_ADD, OP_ADC, OP_SUB, OP_SBC, OP_CMP, OP_CMPC,
         OP_NEG, OP_INC, OP_DEC:                 unit = UNIT_ARITH;
         OP_AND, OP_OR, OP_XOR, OP_COM,
         OP_SWAP, OP_SER, OP_BLD:                unit = UNIT_LOGIC;
         OP_LSL, OP_LSR, OP_ASR, OP_ROL, OP_ROR: unit = UNIT_SHIFT;
         default:                                unit = UNIT_PASS;
      endcase
   end

   always_comb begin
      case (unit)
         UNIT_ARITH: flag_src = ar_res;
         UNIT_LOGIC: flag_src = lg_res;
         UNIT_SHIFT: flag_src = sh_res;
         default:    flag_src = a_i;
      endcase
      // Compares compute flags only; the first operand passes through
      if (op == OP_CMP || op == OP_CMPC)
         res_d = a_i;
      else
         res_d = flag_src;
   end

   // Per-operation flag write set
   logic [ST_W-1:0] st_d;
   logic            zero_now;
   logic            nv_upd;

   assign zero_now = (flag_src == '0);

   always_comb begin
      st_d   = status_i;
      nv_upd = 1'b0;
      case (op)
         OP_ADD, OP_ADC, OP_SUB, OP_CMP, OP_NEG: begin
            st_d[FL_H] = ar_h;
            st_d[FL_C] = ar_c;
            st_d[FL_V] = ar_v;
            st_d[FL_Z] = zero_now;
            nv_upd     = 1'b1;
         end
         OP_SBC, OP_CMPC: begin
            st_d[FL_H] = ar_h;
            st_d[FL_C] = ar_c;
            st_d[FL_V] = ar_v;
            st_d[FL_Z] = zero_now & status_i[FL_Z];
            nv_upd     = 1'b1;
         end
         OP_AND, OP_OR, OP_XOR: begin
            st_d[FL_V] = 1'b0;
            st_d[FL_Z] = zero_now;
            nv_upd     = 1'b1;
         end
         OP_COM: begin
            st_d[FL_C] = 1'b1;
            st_d[FL_V] = 1'b0;
            st_d[FL_Z] = zero_now;
            nv_upd     = 1'b1;
         end
         OP_INC, OP_DEC: begin
            st_d[FL_V] = ar_v;
            st_d[FL_Z] = zero_now;
            nv_upd     = 1'b1;
         end
         OP_LSL, OP_LSR, OP_ASR, OP_ROL, OP_ROR: begin
            st_d[FL_C] = sh_c;
            st_d[FL_V] = flag_src[MSB] ^ sh_c;
            st_d[FL_Z] = zero_now;
            nv_upd     = 1'b1;
         end
         OP_BST:  st_d[FL_T] = lg_bit;
         OP_FSET: st_d[flag_sel_i] = 1'b1;
         OP_FCLR: st_d[flag_sel_i] = 1'b0;
         default: st_d = status_i;
      endcase
      if (nv_upd) begin
         st_d[FL_N] = flag_src[MSB];
         st_d[FL_S] = flag_src[MSB] ^ st_d[FL_V];
      end
   end

   // Output stage variant
   if (OUT_REG) begin : g_out_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            res_o    <= '0;
            status_o <= '0;
         end else begin
            res_o    <= res_d;
            status_o <= st_d;
         end
      end
   end else begin : g_out_comb
      assign res_o    = res_d;
      assign status_o = st_d;
   end

endmodule

// File: rtl/byte_alu_chk.sv
`timescale 1ns/1ps
module byte_alu_chk
   import byte_alu_pkg::*;
#(
   parameter int DATA_W  = 8,
   parameter bit OUT_REG = 1'b1
) (
   input logic              clk,
   input logic              rst_n,
   input logic [4:0]        op_i,
   input logic [DATA_W-1:0] a_i,
   input logic [2:0]        flag_sel_i,
   input logic [7:0]        status_i,
   input logic [DATA_W-1:0] res_o,
   input logic [7:0]        status_o
);
   localparam int HB  = DATA_W / 2;
   localparam int MSB = DATA_W - 1;

   if (OUT_REG) begin : g_seq
      logic primed;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) primed <= 1'b0;
         else        primed <= 1'b1;
      end

      a_r10_swap_keeps_status: assert property (@(posedge clk) disable iff (!rst_n)
         primed && $past(op_i) == OP_SWAP |->
            status_o == $past(status_i) &&
            res_o == {$past(a_i[HB-1:0]), $past(a_i[MSB:HB])});

      a_r4_zero_never_newly_set: assert property (@(posedge clk) disable iff (!rst_n)
         primed && ($past(op_i) == OP_SBC || $past(op_i) == OP_CMPC) &&
         !$past(status_i[FL_Z]) |-> !status_o[FL_Z]);

      a_r5_logic_keeps_carry: assert property (@(posedge clk) disable iff (!rst_n)
         primed && ($past(op_i) == OP_AND || $past(op_i) == OP_OR || $past(op_i) == OP_XOR) |->
            status_o[FL_C] == $past(status_i[FL_C]) &&
            status_o[FL_H] == $past(status_i[FL_H]) && !status_o[FL_V]);

      a_r13_i_bit_fixed: assert property (@(posedge clk) disable iff (!rst_n)
         primed && $past(op_i) != OP_FSET && $past(op_i) != OP_FCLR |->
            status_o[FL_I] == $past(status_i[FL_I]));

      a_r12_flag_set: assert property (@(posedge clk) disable iff (!rst_n)
         primed && $past(op_i) == OP_FSET |-> status_o[$past(flag_sel_i)]);

      a_r3_compare_returns_a: assert property (@(posedge clk) disable iff (!rst_n)
         primed && ($past(op_i) == OP_CMP || $past(op_i) == OP_CMPC) |-> res_o == $past(a_i));

      a_r2_add_sign_and_zero: assert property (@(posedge clk) disable iff (!rst_n)
         primed && $past(op_i) == OP_ADD |->
            status_o[FL_S] == (status_o[FL_N] ^ status_o[FL_V]) &&
            status_o[FL_Z] == (res_o == '0));
   end

endmodule

bind byte_alu byte_alu_chk #(.DATA_W(DATA_W), .OUT_REG(OUT_REG)) i_byte_alu_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .op_i       (op_i),
   .a_i        (a_i),
   .flag_sel_i (flag_sel_i),
   .status_i   (status_i),
   .res_o      (res_o),
   .status_o   (status_o)
);

// File: tb/test_byte_alu.sv
`timescale 1ns/1ps
module test_byte_alu;
   import byte_alu_pkg::*;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [4:0] op = '0;
   logic [7:0] a = '0, b = '0, st = '0;
   logic [2:0] bsel = '0, fsel = '0;
   logic [7:0] res, st_o;
   int n_checks = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   byte_alu i_byte_alu (
      .clk(clk), .rst_n(rst_n), .op_i(op), .a_i(a), .b_i(b),
      .bit_sel_i(bsel), .flag_sel_i(fsel), .status_i(st),
      .res_o(res), .status_o(st_o)
   );

   task automatic chk(input string tag, input logic [7:0] er, input logic [7:0] es);
      n_checks++;
      if (res !== er || st_o !== es) begin
         n_fail++;
         $display("FAIL %s: op=%0d a=%h b=%h st=%h -> res=%h status=%h, expected res=%h status=%h",
                  tag, op, a, b, st, res, st_o, er, es);
      end
   endtask

   task automatic drive(input logic [4:0] o, input logic [7:0] xa, input logic [7:0] xb,
                        input logic [2:0] bs, input logic [2:0] fs, input logic [7:0] s);
      @(negedge clk);
      op = o; a = xa; b = xb; bsel = bs; fsel = fs; st = s;
      @(negedge clk);
   endtask

   task automatic run(input string tag, input logic [4:0] o, input logic [7:0] xa,
                      input logic [7:0] xb, input logic [2:0] bs, input logic [2:0] fs,
                      input logic [7:0] s, input logic [7:0] er, input logic [7:0] es);
      drive(o, xa, xb, bs, fs, s);
      chk(tag, er, es);
   endtask

   // Independent flag model written from the requirement text
   function automatic logic [15:0] ref_alu(input logic [4:0] o, input logic [7:0] x,
                                           input logic [7:0] y, input logic [2:0] bs,
                                           input logic [2:0] fs, input logic [7:0] si);
      logic [7:0] r, so, outv;
      logic c, v, upd, sticky, cc;
      r = x; so = si; c = si[0]; v = 1'b0; upd = 1'b0; sticky = 1'b0; cc = 1'b0;
      case (o)
         OP_ADD, OP_ADC: begin
            cc = (o == OP_ADC) ? c : 1'b0;
            r = x + y + {7'd0, cc};
            so[5] = (x[3] & y[3]) | (y[3] & ~r[3]) | (~r[3] & x[3]);
            so[0] = (x[7] & y[7]) | (y[7] & ~r[7]) | (~r[7] & x[7]);
            v = (x[7] & y[7] & ~r[7]) | (~x[7] & ~y[7] & r[7]);
            upd = 1'b1;
         end
         OP_SUB, OP_SBC, OP_CMP, OP_CMPC: begin
            sticky = (o == OP_SBC || o == OP_CMPC);
            cc = sticky ? c : 1'b0;
            r = x - y - {7'd0, cc};
            so[5] = (~x[3] & y[3]) | (y[3] & r[3]) | (r[3] & ~x[3]);
            so[0] = (~x[7] & y[7]) | (y[7] & r[7]) | (r[7] & ~x[7]);
            v = (x[7] & ~y[7] & ~r[7]) | (~x[7] & y[7] & r[7]);
            upd = 1'b1;
         end
         OP_NEG: begin
            r = 8'd0 - x;
            so[5] = r[3] | x[3];
            so[0] = (r != 8'd0);
            v = (r == 8'h80);
            upd = 1'b1;
         end
         OP_AND: begin r = x & y; upd = 1'b1; end
         OP_OR:  begin r = x | y; upd = 1'b1; end
         OP_XOR: begin r = x ^ y; upd = 1'b1; end
         OP_COM: begin r = 8'hFF - x; so[0] = 1'b1; upd = 1'b1; end
         OP_INC: begin r = x + 8'd1; v = (x == 8'h7F); upd = 1'b1; end
         OP_DEC: begin r = x - 8'd1; v = (x == 8'h80); upd = 1'b1; end
         OP_LSL: begin r = {x[6:0], 1'b0}; so[0] = x[7]; v = r[7] ^ x[7]; upd = 1'b1; end
         OP_LSR: begin r = {1'b0, x[7:1]}; so[0] = x[0]; v = x[0]; upd = 1'b1; end
         OP_ASR: begin r = {x[7], x[7:1]}; so[0] = x[0]; v = x[7] ^ x[0]; upd = 1'b1; end
         OP_ROL: begin r = {x[6:0], c}; so[0] = x[7]; v = x[6] ^ x[7]; upd = 1'b1; end
         OP_ROR: begin r = {c, x[7:1]}; so[0] = x[0]; v = c ^ x[0]; upd = 1'b1; end
         OP_SWAP: r = {x[3:0], x[7:4]};
         OP_SER:  r = 8'hFF;
         OP_BST:  so[6] = x[bs];
         OP_BLD:  r[bs] = si[6];
         OP_FSET: so[fs] = 1'b1;
         OP_FCLR: so[fs] = 1'b0;
         default: r = x;
      endcase
      if (upd) begin
         so[1] = (r == 8'd0) && (sticky ? si[1] : 1'b1);
         so[2] = r[7];
         so[3] = v;
         so[4] = r[7] ^ v;
      end
      outv = (o == OP_CMP || o == OP_CMPC) ? x : r;
      return {outv, so};
   endfunction

   function automatic string tag_of(input logic [4:0] o);
      case (o)
         OP_ADD, OP_ADC:                          return "R2";
         OP_SUB, OP_SBC, OP_CMP, OP_CMPC, OP_NEG: return "R3";
         OP_AND, OP_OR, OP_XOR:                   return "R5";
         OP_INC, OP_DEC:                          return "R6";
         OP_COM:                                  return "R7";
         OP_LSL, OP_LSR, OP_ASR:                  return "R8";
         OP_ROL, OP_ROR:                          return "R9";
         OP_SWAP, OP_SER:                         return "R10";
         OP_BST, OP_BLD:                          return "R11";
         default:                                 return "R12";
      endcase
   endfunction

   function automatic logic [7:0] pat(input int i);
      case (i)
         0: return 8'h00; 1: return 8'h01; 2: return 8'h0F; 3: return 8'h10;
         4: return 8'h7F; 5: return 8'h80; 6: return 8'h81; default: return 8'hFF;
      endcase
   endfunction

   task automatic t_reset_latency;
      // R1: reset values, then one-clock latency
      chk("R1 reset", 8'h00, 8'h00);
      @(negedge clk);
      rst_n = 1'b1;
      op = OP_ADD; a = 8'h02; b = 8'h03; st = 8'h00;
      #1;
      chk("R1 before edge", 8'h00, 8'h00);
      @(negedge clk);
      chk("R1 after edge", 8'h05, 8'h00);
   endtask

   task automatic t_add;
      run("R2 add overflow", OP_ADD, 8'h7F, 8'h01, 0, 0, 8'h00, 8'h80, 8'h2C);
      run("R2 add wrap",     OP_ADD, 8'hFF, 8'h01, 0, 0, 8'h00, 8'h00, 8'h23);
      run("R2 adc carry in", OP_ADC, 8'h0F, 8'h00, 0, 0, 8'h01, 8'h10, 8'h20);
      run("R13 add keeps I T", OP_ADD, 8'h01, 8'h01, 0, 0, 8'hC0, 8'h02, 8'hC0);
   endtask

   task automatic t_sub;
      run("R3 sub overflow", OP_SUB, 8'h80, 8'h01, 0, 0, 8'h00, 8'h7F, 8'h38);
      run("R3 cmp keeps a",  OP_CMP, 8'h05, 8'h07, 0, 0, 8'h00, 8'h05, 8'h35);
      run("R3 neg 0x80",     OP_NEG, 8'h80, 8'h00, 0, 0, 8'h00, 8'h80, 8'h0D);
   endtask

   task automatic t_sticky;
      run("R4 sbc z clear",  OP_SBC,  8'h05, 8'h05, 0, 0, 8'h00, 8'h00, 8'h00);
      run("R4 sbc z kept",   OP_SBC,  8'h05, 8'h05, 0, 0, 8'h02, 8'h00, 8'h02);
      run("R4 cpc z clear",  OP_CMPC, 8'h06, 8'h05, 0, 0, 8'h01, 8'h06, 8'h00);
   endtask

   task automatic t_logic;
      run("R5 and zero", OP_AND, 8'hF0, 8'h0F, 0, 0, 8'hE9, 8'h00, 8'hE3);
      run("R6 inc 7F",   OP_INC, 8'h7F, 8'h00, 0, 0, 8'h01, 8'h80, 8'h0D);
      run("R6 dec 80",   OP_DEC, 8'h80, 8'h00, 0, 0, 8'h01, 8'h7F, 8'h19);
      run("R7 com 00",   OP_COM, 8'h00, 8'h00, 0, 0, 8'h00, 8'hFF, 8'h15);
   endtask

   task automatic t_shift;
      run("R8 lsl",  OP_LSL, 8'h81, 8'h00, 0, 0, 8'h00, 8'h02, 8'h19);
      run("R8 lsr",  OP_LSR, 8'h01, 8'h00, 0, 0, 8'h00, 8'h00, 8'h1B);
      run("R8 asr",  OP_ASR, 8'h80, 8'h00, 0, 0, 8'h00, 8'hC0, 8'h0C);
      run("R9 rol",  OP_ROL, 8'h80, 8'h00, 0, 0, 8'h01, 8'h01, 8'h19);
      run("R9 ror",  OP_ROR, 8'h01, 8'h00, 0, 0, 8'h00, 8'h00, 8'h1B);
   endtask

   task automatic t_bits_flags;
      run("R10 swap", OP_SWAP, 8'h3C, 8'h00, 0, 0, 8'hA5, 8'hC3, 8'hA5);
      run("R10 ser",  OP_SER,  8'h12, 8'h00, 0, 0, 8'hA5, 8'hFF, 8'hA5);
      run("R11 bst",  OP_BST,  8'h10, 8'h00, 4, 0, 8'h00, 8'h10, 8'h40);
      run("R11 bld",  OP_BLD,  8'h00, 8'h00, 7, 0, 8'h40, 8'h80, 8'h40);
      run("R12 fset", OP_FSET, 8'h21, 8'h00, 0, 7, 8'h00, 8'h21, 8'h80);
      run("R12 fclr", OP_FCLR, 8'h21, 8'h00, 0, 0, 8'hFF, 8'h21, 8'hFE);
      run("R12 unused code", 5'd31, 8'h5A, 8'h00, 0, 0, 8'h33, 8'h5A, 8'h33);
   endtask

   task automatic t_sweep;
      for (int oi = 0; oi < 24; oi++) begin
         for (int ai = 0; ai < 8; ai++) begin
            for (int bi = 0; bi < 4; bi++) begin
               for (int si = 0; si < 2; si++) begin
                  logic [15:0] e;
                  logic [7:0]  s0;
                  s0 = (si == 0) ? 8'h00 : 8'hFF;
                  e = ref_alu(5'(oi), pat(ai), pat(bi * 2 + 1), 3'(ai), 3'(bi + si), s0);
                  drive(5'(oi), pat(ai), pat(bi * 2 + 1), 3'(ai), 3'(bi + si), s0);
                  chk({tag_of(5'(oi)), " sweep"}, e[15:8], e[7:0]);
               end
            end
         end
      end
   endtask

   task automatic summary;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: run did not complete, expected completion");
         summary();
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      t_reset_latency();
      t_add();
      t_sub();
      t_sticky();
      t_logic();
      t_shift();
      t_bits_flags();
      t_sweep();
      done = 1'b1;
      summary();
      $finish;
   end

endmodule